// File: doc/BRIEF.md
# Wake-up Frame Pattern Matcher

While the device sleeps, this block watches received frames for up to three programmable wake-up patterns. Each pattern slot has four settings: a 128-bit byte-select mask, a starting byte offset into the frame, a 16-bit expected checksum and an enable bit. For every byte the mask selects, the slot folds that byte into its own CRC-16. When the frame ends, each enabled slot compares its CRC with the stored value. A match on any enabled slot sets a sticky wake-up flag and raises a one-cycle wake request.

Received data arrives as a byte stream framed by a start strobe and an end strobe. A single option picks the CRC seed (all zeros or all ones) for every slot. The block also keeps a second sticky flag that records link-status changes. A status-read strobe clears both flags.

Top module: `wkf_match_top`

## Requirements
- R1: There are three slots. Slot s reads its configuration from flat vectors: mask bit i is `cfg_mask[s*128+i]`, the byte offset is `cfg_off[s*8+7:s*8]`, and the expected CRC is `cfg_crc[s*16+15:s*16]` (low byte in bits 7:0, high byte in bits 15:8). Slot s is enabled by `slot_en[s]`.
- R2: Bytes are numbered from 0, starting with the first byte after `frm_start`. Byte p enters slot s's CRC only when off <= p < off+128 and mask bit (p-off) is set. No other byte ever contributes.
- R3: The CRC uses polynomial 8005h in reflected form. Each byte is processed bit 0 first: when (crc[0] xor bit) is 1, crc becomes (crc>>1) xor A001h; otherwise crc becomes crc>>1. No final inversion is applied.
- R4: Every slot loads its CRC seed at `frm_start`. The seed is 0000h when `seed_ones`=0 and FFFFh when `seed_ones`=1.
- R5: Comparison happens only when `frm_end` is high. A frame that ends inside a slot's window is compared using the bytes received so far.
- R6: A slot with its enable bit clear never sets the wake-up flag, even if its CRC matches.
- R7: `wake_flag` rises after the clock edge that samples `frm_end` with a match on an enabled slot. It then stays set until `stat_rd` is sampled. If a match and `stat_rd` occur in the same cycle, the set wins.
- R8: `wake_req` is high for exactly the one cycle in which `wake_flag` goes from 0 to 1. A match while the flag is already set gives no pulse.
- R9: `link_flag` is set by `link_chg` and cleared by `stat_rd`, with set winning when both occur together. It has no effect on `wake_flag`.
- R10: After reset, `wake_flag`, `wake_req` and `link_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Frame start strobe; carries no data |
| byte_vld | input | 1 | `byte_dat` holds a frame byte |
| byte_dat | input | 8 | Frame byte |
| frm_end | input | 1 | Frame end strobe; carries no data |
| slot_en | input | 3 | Per-slot enable |
| seed_ones | input | 1 | CRC seed select: 0 gives 0000h, 1 gives FFFFh |
| cfg_mask | input | 384 | Byte masks of all slots |
| cfg_off | input | 24 | Byte offsets of all slots |
| cfg_crc | input | 48 | Expected CRC values of all slots |
| link_chg | input | 1 | Link-status change event |
| stat_rd | input | 1 | Status read; clears both flags |
| wake_flag | output | 1 | Sticky wake-up frame received flag |
| link_flag | output | 1 | Sticky link-change flag |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The assertions assume that `frm_start`, `byte_vld` and `frm_end` are never high in the same cycle, and that the configuration stays fixed for the whole of a frame. The bench drives each strobe and each byte in a cycle of its own. It changes the configuration only between frames, while no strobe is active. Expected CRCs come from a bit-reversed, MSB-first model in the bench, which is computed differently from the RTL's reflected update.

// File: rtl/wkf_pkg.sv
`timescale 1ns/1ps
package wkf_pkg;
   localparam int unsigned CRC_W = 16;
   localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;

   // one byte into a reflected CRC-16, bit 0 first
   function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                 input logic [7:0] d);
      logic [CRC_W-1:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         if (r[0] ^ d[b]) r = (r >> 1) ^ POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/wkf_pos.sv
`timescale 1ns/1ps
module wkf_pos #(
   parameter int unsigned POS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_start,
   input  logic             byte_vld,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

   // saturates so that a long frame never wraps back into a window
   always_ff @(posedge clk) begin
      if (!rst_n)                         pos <= '0;
      else if (frm_start)                 pos <= '0;
      else if (byte_vld && pos != POS_MAX) pos <= pos + 1'b1;
   end
endmodule

// File: rtl/wkf_lane.sv
`timescale 1ns/1ps
module wkf_lane
   import wkf_pkg::*;
#(
   parameter int unsigned MASK_BITS = 128,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned POS_W     = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_start,
   input  logic                 byte_vld,
   input  logic [7:0]           byte_dat,
   input  logic [POS_W-1:0]     pos,
   input  logic                 seed_ones,
   input  logic [MASK_BITS-1:0] mask,
   input  logic [OFF_W-1:0]     off,
   input  logic [CRC_W-1:0]     exp_crc,
   output logic                 hit
);
   localparam int unsigned IDX_W = (MASK_BITS > 1) ? $clog2(MASK_BITS) : 1;
   localparam logic [POS_W-1:0] WIN = POS_W'(MASK_BITS);

   logic [POS_W-1:0] off_ext, rel;
   logic             in_win, take;
   logic [CRC_W-1:0] crc;

   assign off_ext = POS_W'(off);
   assign rel     = pos - off_ext;
   assign in_win  = (pos >= off_ext) && (rel < WIN);
   assign take    = byte_vld && in_win && mask[rel[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n)         crc <= '0;
      else if (frm_start) crc <= seed_ones ? {CRC_W{1'b1}} : '0;
      else if (take)      crc <= crc_byte(crc, byte_dat);
   end

   assign hit = (crc == exp_crc);
endmodule

// File: rtl/wkf_sticky.sv
`timescale 1ns/1ps
module wkf_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   logic q_nx;

   generate
      if (SET_WINS) begin : g_set_first
         assign q_nx = set | (q & ~clr);
      end else begin : g_clr_first
         assign q_nx = ~clr & (set | q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nx;
   end
endmodule

// File: rtl/wkf_match_top.sv
`timescale 1ns/1ps
module wkf_match_top
   import wkf_pkg::*;
#(
   parameter int unsigned NSLOT     = 3,
   parameter int unsigned MASK_BITS = 128,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned POS_W     = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frm_start,
   input  logic                       byte_vld,
   input  logic [7:0]                 byte_dat,
   input  logic                       frm_end,
   input  logic [NSLOT-1:0]           slot_en,
   input  logic                       seed_ones,
   input  logic [NSLOT*MASK_BITS-1:0] cfg_mask,
   input  logic [NSLOT*OFF_W-1:0]     cfg_off,
   input  logic [NSLOT*CRC_W-1:0]     cfg_crc,
   input  logic                       link_chg,
   input  logic                       stat_rd,
   output logic                       wake_flag,
   output logic                       link_flag,
   output logic                       wake_req
);
   localparam int unsigned REACH = (1 << OFF_W) + MASK_BITS;

   if (NSLOT < 1)              $error("NSLOT must be at least 1");
   if (MASK_BITS < 1)          $error("MASK_BITS must be at least 1");
   if ((1 << POS_W) <= REACH)  $error("POS_W too small for offset plus window");

   logic [POS_W-1:0] pos;
   logic [NSLOT-1:0] hit;
   logic             frame_hit;

   wkf_pos #(.POS_W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
      .byte_vld(byte_vld), .pos(pos)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      wkf_lane #(.MASK_BITS(MASK_BITS), .OFF_W(OFF_W), .POS_W(POS_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
         .byte_vld(byte_vld), .byte_dat(byte_dat), .pos(pos),
         .seed_ones(seed_ones),
         .mask(cfg_mask[s*MASK_BITS +: MASK_BITS]),
         .off(cfg_off[s*OFF_W +: OFF_W]),
         .exp_crc(cfg_crc[s*CRC_W +: CRC_W]),
         .hit(hit[s])
      );
   end

   assign frame_hit = frm_end && |(hit & slot_en);

   wkf_sticky #(.SET_WINS(1'b1)) u_wake (
      .clk(clk), .rst_n(rst_n), .set(frame_hit), .clr(stat_rd), .q(wake_flag)
   );

   wkf_sticky #(.SET_WINS(1'b1)) u_link (
      .clk(clk), .rst_n(rst_n), .set(link_chg), .clr(stat_rd), .q(link_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) wake_req <= 1'b0;
      else        wake_req <= frame_hit && !wake_flag;
   end
endmodule

// File: rtl/wkf_match_chk.sv
`timescale 1ns/1ps
module wkf_match_chk #(
   parameter int unsigned NSLOT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_start,
   input logic             byte_vld,
   input logic             frm_end,
   input logic [NSLOT-1:0] slot_en,
   input logic             link_chg,
   input logic             stat_rd,
   input logic             wake_flag,
   input logic             link_flag,
   input logic             wake_req
);
   a_in_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frm_start, byte_vld, frm_end}));

   a_r5_rise_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(frm_end));

   a_r6_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_end && slot_en == '0 && !wake_flag) |=> !wake_flag);

   a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && !stat_rd) |=> wake_flag);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !frm_end) |=> !wake_flag);

   a_r8_req_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> wake_req);

   a_r8_req_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($rose(wake_flag) && !$past(wake_flag)));

   a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   a_r9_link_set: assert property (@(posedge clk) disable iff (!rst_n)
      link_chg |=> link_flag);

   a_r9_link_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (link_flag && !stat_rd) |=> link_flag);
endmodule

bind wkf_match_top wkf_match_chk #(.NSLOT(NSLOT)) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
   .frm_end(frm_end), .slot_en(slot_en), .link_chg(link_chg),
   .stat_rd(stat_rd), .wake_flag(wake_flag), .link_flag(link_flag),
   .wake_req(wake_req)
);

// File: tb/sim_wkf_match_top.sv
`timescale 1ns/1ps
module sim_wkf_match_top;
   localparam int NS = 3;
   localparam int MB = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frm_start = 0, byte_vld = 0, frm_end = 0;
   logic [7:0]        byte_dat = '0;
   logic [NS-1:0]     slot_en = '0;
   logic              seed_ones = 0;
   logic [NS*MB-1:0]  cfg_mask = '0;
   logic [NS*8-1:0]   cfg_off = '0;
   logic [NS*16-1:0]  cfg_crc = '0;
   logic              link_chg = 0, stat_rd = 0;
   logic              wake_flag, link_flag, wake_req;

   int total = 0;
   int bad = 0;
   bit flag_model = 0;
   logic [7:0] frm [0:511];

   typedef struct { bit flag; bit req; string tag; } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   wkf_match_top u0 (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .frm_end(frm_end), .slot_en(slot_en),
      .seed_ones(seed_ones), .cfg_mask(cfg_mask), .cfg_off(cfg_off),
      .cfg_crc(cfg_crc), .link_chg(link_chg), .stat_rd(stat_rd),
      .wake_flag(wake_flag), .link_flag(link_flag), .wake_req(wake_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   // model: MSB-first 8005h on a bit-reversed register
   function automatic logic [15:0] ref_crc(input int s, input int len);
      logic [15:0] reg_r;
      int o;
      reg_r = rev16(seed_ones ? 16'hFFFF : 16'h0000);
      o = int'(cfg_off[s*8 +: 8]);
      for (int p = 0; p < len; p++) begin
         if (p >= o && p < o + MB && cfg_mask[s*MB + (p - o)]) begin
            for (int b = 0; b < 8; b++) begin
               bit fb;
               fb = reg_r[15] ^ frm[p][b];
               reg_r = {reg_r[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
         end
      end
      return rev16(reg_r);
   endfunction

   // driver: pushes the expected outcome, then drives the frame
   task automatic send_frame(input int len, input string tag);
      exp_t e;
      bit any;
      any = 0;
      for (int s = 0; s < NS; s++)
         if (slot_en[s] && ref_crc(s, len) == cfg_crc[s*16 +: 16]) any = 1;
      e.req = any && !flag_model;
      flag_model = flag_model | any;
      e.flag = flag_model;
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk) frm_start = 1;
      @(negedge clk) frm_start = 0;
      for (int i = 0; i < len; i++) begin
         byte_vld = 1; byte_dat = frm[i];
         @(negedge clk);
      end
      byte_vld = 0; frm_end = 1;
      @(negedge clk) frm_end = 0;
      @(negedge clk);
   endtask

   task automatic read_status();
      @(negedge clk) stat_rd = 1;
      @(negedge clk) stat_rd = 0;
      flag_model = 0;
   endtask

   // monitor: compares at the negedge after the edge that sampled frm_end
   bit end_q = 0;
   always @(posedge clk) end_q <= frm_end;
   always @(negedge clk) begin
      if (end_q) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard empty actual=1 expected=0");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " wake_flag"}, 32'(wake_flag), 32'(e.flag));
            check({e.tag, " wake_req"},  32'(wake_req),  32'(e.req));
         end
      end
   end

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) frm[i] = 8'((i * 37 + 5) ^ (i >> 3));
      repeat (3) @(negedge clk);
      check("R10 wake_flag reset", 32'(wake_flag), 0);
      check("R10 wake_req reset", 32'(wake_req), 0);
      check("R10 link_flag reset", 32'(link_flag), 0);
      rst_n = 1;
      @(negedge clk);

      // R2 R3 R4: slot 0, offset 0, bytes 0..5, seed zero, matching
      slot_en = 3'b001; seed_ones = 0;
      cfg_mask[0 +: MB] = 128'h3F;
      cfg_crc[0 +: 16] = ref_crc(0, 20);
      send_frame(20, "R3 slot0 match");
      read_status();
      check("R7 cleared by read", 32'(wake_flag), 0);

      // R1 wrong expected CRC
      cfg_crc[0 +: 16] = cfg_crc[0 +: 16] ^ 16'h0100;
      send_frame(20, "R1 slot0 mismatch");

      // R6 disabled slot with matching CRC
      cfg_crc[0 +: 16] = ref_crc(0, 20);
      slot_en = 3'b000;
      send_frame(20, "R6 disabled slot");

      // R2 R4: slot 1, offset 10, sparse mask incl. bit 127, seed ones
      slot_en = 3'b010; seed_ones = 1;
      cfg_off[8 +: 8] = 8'd10;
      cfg_mask[MB +: MB] = {1'b1, 118'b0, 9'b000001001};
      cfg_crc[16 +: 16] = ref_crc(1, 150);
      send_frame(150, "R2 slot1 offset window");
      read_status();

      // R4 same slot with zero seed: compare against model outcome
      seed_ones = 0;
      send_frame(150, "R4 seed zero");
      seed_ones = 1;
      send_frame(150, "R4 seed ones again");
      read_status();

      // R5 short frame inside window
      slot_en = 3'b100;
      cfg_off[16 +: 8] = 8'd4;
      cfg_mask[2*MB +: MB] = {MB{1'b1}};
      cfg_crc[32 +: 16] = ref_crc(2, 9);
      send_frame(9, "R5 short frame");
      read_status();
      send_frame(12, "R5 longer frame no match");

      // R2 bytes past window ignored: 200-byte frame, full mask at offset 0
      slot_en = 3'b001;
      cfg_mask[0 +: MB] = {MB{1'b1}};
      cfg_off[0 +: 8] = 8'd0;
      for (int i = 128; i < 200; i++) frm[i] = 8'hA5;
      cfg_crc[0 +: 16] = ref_crc(0, 128);
      send_frame(200, "R2 tail ignored");
      // R8 second match while set: no pulse
      send_frame(200, "R8 sticky no pulse");
      read_status();

      // R9 link flag
      @(negedge clk) link_chg = 1;
      @(negedge clk) link_chg = 0;
      check("R9 link set", 32'(link_flag), 1);
      check("R9 wake unaffected", 32'(wake_flag), 0);
      @(negedge clk) begin link_chg = 1; stat_rd = 1; end
      @(negedge clk) begin link_chg = 0; stat_rd = 0; end
      check("R9 set wins over read", 32'(link_flag), 1);
      read_status();
      check("R9 link cleared", 32'(link_flag), 0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule